// File: doc/BRIEF.md
# Configuration Pattern Guard with Corrective Write

The block watches the write traffic of a shared bus through a snoop port. It sorts each write it sees into a small set of events: a divisor write that is below the safe minimum, a divisor write at or above it, a clock-source write, a source write and a counter-enable write. A two-state sequencer follows the repeated pattern "unsafe divisor, then any number of source or clock-source writes, then counter enable". Two 16-bit shadow registers keep the last value written to the clock-source and source locations.

Each time the pattern completes, the block checks the two shadows, using any value written in that same cycle. If the two selector fields hold the one combination that is known to be unsafe, it raises a single write request. The request tells a bus master to put the safe divisor back into the divisor location. The request uses a valid/ready handshake. The master that carries out the write is not part of this block.

Top module: `cfg_pattern_guard`

## Requirements
- R1: After reset `req_valid_o` is 0, the sequencer is idle and both shadows hold zero. A pattern that completes without a clock-source write therefore raises no request.
- R2: Only snooped writes with `snoop_is_mem_i`=1 count as events. I/O writes, and memory writes to offsets other than 0x228, 0x220 and 0x300 from `base_addr_i`, change neither the shadows nor the sequencer.
- R3: A write to offset 0x228 is an unsafe divisor when data[15:0] is 0 to 44. It is a safe divisor when data[15:0] is 45 to 65535.
- R4: From idle, an unsafe divisor arms the sequencer. While armed, source and clock-source writes keep it armed. A counter enable completes the pattern and returns the sequencer to idle, so the pattern can be matched again and again.
- R5: While armed, any divisor write, safe or unsafe, returns the sequencer to idle without a match. A counter enable seen while idle does nothing.
- R6: A write to offset 0x220 is a source write. It is also a counter enable when data bit 0 is 1. With bit 0 equal to 0 it is a source write only.
- R7: A write to offset 0x300 loads data[15:0] into the clock-source shadow, and a write to offset 0x220 loads it into the source shadow. This happens whatever the sequencer state. The check at a match uses the value written in the matching cycle.
- R8: A match raises a request only when clock-source shadow bits [2:1] = 01 and source shadow bits [2:1] = 00.
- R9: A request has `req_valid_o`=1 from the clock edge that sampled the counter-enable write. It carries address `base_addr_i`+0x228 (the base as sampled at that edge), data 45, `req_is_mem_o`=1 and `req_be_o`=0011.
- R10: `req_valid_o` and all request fields stay unchanged until `req_ready_i` is 1 at a clock edge. `req_valid_o` falls at that edge.
- R11: A qualifying match that occurs while `req_valid_o` is 1 is dropped. No second request follows the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_addr_i | input | ADDR_W | Base address of the monitored register window |
| snoop_valid_i | input | 1 | A bus write is present this cycle |
| snoop_is_mem_i | input | 1 | 1 = memory space write, 0 = I/O space write |
| snoop_addr_i | input | ADDR_W | Address of the snooped write |
| snoop_data_i | input | SHADOW_W | Low data lane of the snooped write |
| req_valid_o | output | 1 | Corrective write request pending |
| req_ready_i | input | 1 | Master accepts the pending request |
| req_addr_o | output | ADDR_W | Corrective write address |
| req_data_o | output | DATA_W | Corrective write data |
| req_is_mem_o | output | 1 | Corrective write targets memory space |
| req_be_o | output | DATA_W/8 | Corrective write byte enables |

## Verification
Every result is registered exactly once. A snooped write sampled at one rising edge affects the shadows, the sequencer and `req_valid_o` at that same edge. An acknowledge sampled at an edge clears `req_valid_o` at that edge. The bench drives inputs on falling edges and compares the outputs with its behavioural model at the next falling edge, which is half a cycle after the edge that produces them. Directed checks that follow each write or acknowledge task are sampled at that same falling edge.

// File: rtl/cfg_pattern_guard_pkg.sv
package cfg_pattern_guard_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic div_low;
    logic div_ok;
    logic cnt_on;
    logic src_wr;
    logic clk_wr;
  } snoop_evt_t;

  localparam int unsigned NUM_SHADOWS = 2;
  localparam int unsigned SH_CLK      = 0;
  localparam int unsigned SH_SRC      = 1;

endpackage

// File: rtl/cfg_pattern_guard_decode.sv
module cfg_pattern_guard_decode
  import cfg_pattern_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SHADOW_W = 16,
  parameter int unsigned DIV_OFS  = 'h228,
  parameter int unsigned CNT_OFS  = 'h220,
  parameter int unsigned CLK_OFS  = 'h300,
  parameter int unsigned SAFE_DIV = 45
) (
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic                snoop_valid_i,
  input  logic                snoop_is_mem_i,
  input  logic [ADDR_W-1:0]   snoop_addr_i,
  input  logic [SHADOW_W-1:0] snoop_data_i,
  output snoop_evt_t          evt_o
);

  logic [ADDR_W-1:0] ofs;
  logic              hit;
  logic              at_div, at_cnt, at_clk;

  assign ofs    = snoop_addr_i - base_addr_i;
  assign hit    = snoop_valid_i && snoop_is_mem_i;
  assign at_div = hit && (ofs == ADDR_W'(DIV_OFS));
  assign at_cnt = hit && (ofs == ADDR_W'(CNT_OFS));
  assign at_clk = hit && (ofs == ADDR_W'(CLK_OFS));

  always_comb begin
    evt_o         = '0;
    evt_o.div_low = at_div && (snoop_data_i <  SHADOW_W'(SAFE_DIV));
    evt_o.div_ok  = at_div && (snoop_data_i >= SHADOW_W'(SAFE_DIV));
    evt_o.cnt_on  = at_cnt && snoop_data_i[0];
    evt_o.src_wr  = at_cnt;
    evt_o.clk_wr  = at_clk;
  end

endmodule

// File: rtl/cfg_pattern_guard_seq.sv
module cfg_pattern_guard_seq
  import cfg_pattern_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_low_i,
  input  logic div_ok_i,
  input  logic cnt_on_i,
  output logic match_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (div_low_i) state_d = SEQ_ARMED;
      // setter-only writes keep the sequencer armed
      SEQ_ARMED: if (div_low_i || div_ok_i || cnt_on_i) state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  assign match_o = (state_q == SEQ_ARMED) && cnt_on_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/cfg_pattern_guard_shadow.sv
module cfg_pattern_guard_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] next_o
);

  logic [W-1:0] q;

  // same-cycle write is visible to the match check
  assign next_o = load_i ? data_i : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= next_o;
  end

endmodule

// File: rtl/cfg_pattern_guard_req.sv
module cfg_pattern_guard_req #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SHADOW_W = 16,
  parameter int unsigned DIV_OFS  = 'h228,
  parameter int unsigned SAFE_DIV = 45
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [ADDR_W-1:0]    req_addr_o,
  output logic [DATA_W-1:0]    req_data_o,
  output logic                 req_is_mem_o,
  output logic [DATA_W/8-1:0]  req_be_o
);

  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned SH_BYTES = SHADOW_W / 8;
  localparam logic [BE_W-1:0] FIX_BE = BE_W'((1 << SH_BYTES) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o  <= 1'b0;
      req_addr_o   <= '0;
      req_data_o   <= '0;
      req_is_mem_o <= 1'b0;
      req_be_o     <= '0;
    end else if (req_valid_o) begin
      // pending: matches are dropped, only the handshake moves
      if (req_ready_i) req_valid_o <= 1'b0;
    end else if (fire_i) begin
      req_valid_o  <= 1'b1;
      req_addr_o   <= base_addr_i + ADDR_W'(DIV_OFS);
      req_data_o   <= DATA_W'(SAFE_DIV);
      req_is_mem_o <= 1'b1;
      req_be_o     <= FIX_BE;
    end
  end

endmodule

// File: rtl/cfg_pattern_guard.sv
module cfg_pattern_guard
  import cfg_pattern_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SHADOW_W   = 16,
  parameter int unsigned DIV_OFS    = 'h228,
  parameter int unsigned CNT_OFS    = 'h220,
  parameter int unsigned CLK_OFS    = 'h300,
  parameter int unsigned SAFE_DIV   = 45,
  parameter int unsigned SEL_LSB    = 1,
  parameter int unsigned CLK_UNSAFE = 1,
  parameter int unsigned SRC_UNSAFE = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    base_addr_i,
  input  logic                 snoop_valid_i,
  input  logic                 snoop_is_mem_i,
  input  logic [ADDR_W-1:0]    snoop_addr_i,
  input  logic [SHADOW_W-1:0]  snoop_data_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [ADDR_W-1:0]    req_addr_o,
  output logic [DATA_W-1:0]    req_data_o,
  output logic                 req_is_mem_o,
  output logic [DATA_W/8-1:0]  req_be_o
);

  localparam int unsigned SEL_W = 2;

  snoop_evt_t    evt;
  logic          match;
  logic          fire;
  logic [SHADOW_W-1:0] sh_next [NUM_SHADOWS];
  logic [NUM_SHADOWS-1:0] sh_load;
  logic [SEL_W-1:0] clk_sel, src_sel;

  cfg_pattern_guard_decode #(
    .ADDR_W   (ADDR_W),
    .SHADOW_W (SHADOW_W),
    .DIV_OFS  (DIV_OFS),
    .CNT_OFS  (CNT_OFS),
    .CLK_OFS  (CLK_OFS),
    .SAFE_DIV (SAFE_DIV)
  ) u_decode (
    .base_addr_i    (base_addr_i),
    .snoop_valid_i  (snoop_valid_i),
    .snoop_is_mem_i (snoop_is_mem_i),
    .snoop_addr_i   (snoop_addr_i),
    .snoop_data_i   (snoop_data_i),
    .evt_o          (evt)
  );

  cfg_pattern_guard_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_low_i (evt.div_low),
    .div_ok_i  (evt.div_ok),
    .cnt_on_i  (evt.cnt_on),
    .match_o   (match)
  );

  assign sh_load[SH_CLK] = evt.clk_wr;
  assign sh_load[SH_SRC] = evt.src_wr;

  for (genvar g = 0; g < NUM_SHADOWS; g++) begin : g_shadow
    cfg_pattern_guard_shadow #(
      .W (SHADOW_W)
    ) u_shadow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (sh_load[g]),
      .data_i (snoop_data_i),
      .next_o (sh_next[g])
    );
  end

  assign clk_sel = sh_next[SH_CLK][SEL_LSB +: SEL_W];
  assign src_sel = sh_next[SH_SRC][SEL_LSB +: SEL_W];
  assign fire    = match && (clk_sel == SEL_W'(CLK_UNSAFE))
                         && (src_sel == SEL_W'(SRC_UNSAFE));

  cfg_pattern_guard_req #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SHADOW_W (SHADOW_W),
    .DIV_OFS  (DIV_OFS),
    .SAFE_DIV (SAFE_DIV)
  ) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .base_addr_i  (base_addr_i),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .req_data_o   (req_data_o),
    .req_is_mem_o (req_is_mem_o),
    .req_be_o     (req_be_o)
  );

endmodule

// File: rtl/cfg_pattern_guard_chk.sv
module cfg_pattern_guard_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SHADOW_W = 16,
  parameter int unsigned DIV_OFS  = 'h228,
  parameter int unsigned CNT_OFS  = 'h220,
  parameter int unsigned SAFE_DIV = 45
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   base_addr_i,
  input logic                snoop_valid_i,
  input logic                snoop_is_mem_i,
  input logic [ADDR_W-1:0]   snoop_addr_i,
  input logic                snoop_bit0_i,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [ADDR_W-1:0]   req_addr_o,
  input logic [DATA_W-1:0]   req_data_o,
  input logic                req_is_mem_o,
  input logic [DATA_W/8-1:0] req_be_o
);

  localparam int unsigned BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] EXP_BE = BE_W'((1 << (SHADOW_W / 8)) - 1);

  // R10
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_data_o) && $stable(req_be_o) && $stable(req_is_mem_o));

  // R10
  drop_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);

  // R9
  req_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_is_mem_o && (req_data_o == DATA_W'(SAFE_DIV))
      && (req_be_o == EXP_BE));

  // R9
  issue_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(snoop_valid_i && snoop_is_mem_i && snoop_bit0_i
      && ((snoop_addr_i - base_addr_i) == ADDR_W'(CNT_OFS))));

  // R9
  issue_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> req_addr_o == $past(base_addr_i) + ADDR_W'(DIV_OFS));

endmodule

bind cfg_pattern_guard cfg_pattern_guard_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SHADOW_W (SHADOW_W),
  .DIV_OFS  (DIV_OFS),
  .CNT_OFS  (CNT_OFS),
  .SAFE_DIV (SAFE_DIV)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .base_addr_i    (base_addr_i),
  .snoop_valid_i  (snoop_valid_i),
  .snoop_is_mem_i (snoop_is_mem_i),
  .snoop_addr_i   (snoop_addr_i),
  .snoop_bit0_i   (snoop_data_i[0]),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_addr_o     (req_addr_o),
  .req_data_o     (req_data_o),
  .req_is_mem_o   (req_is_mem_o),
  .req_be_o       (req_be_o)
);

// File: tb/cfg_pattern_guard_bench.sv
`timescale 1ns/1ps
module cfg_pattern_guard_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 16;
  localparam int OFS_DIV = 'h228;
  localparam int OFS_CNT = 'h220;
  localparam int OFS_CLK = 'h300;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] base_addr_i = 32'h4000_0000;
  logic snoop_valid_i = 1'b0, snoop_is_mem_i = 1'b0;
  logic [AW-1:0] snoop_addr_i = '0;
  logic [SW-1:0] snoop_data_i = '0;
  logic req_valid_o, req_ready_i = 1'b0, req_is_mem_o;
  logic [AW-1:0] req_addr_o;
  logic [DW-1:0] req_data_o;
  logic [DW/8-1:0] req_be_o;

  always #2.5 clk_i = ~clk_i;

  cfg_pattern_guard u_cfg_pattern_guard (
    .clk_i, .rst_ni, .base_addr_i, .snoop_valid_i, .snoop_is_mem_i,
    .snoop_addr_i, .snoop_data_i, .req_valid_o, .req_ready_i,
    .req_addr_o, .req_data_o, .req_is_mem_o, .req_be_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit      m_armed, m_valid;
  int      m_clk, m_src;
  longint  m_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_armed = 0; m_valid = 0; m_clk = 0; m_src = 0; m_addr = 0;
    end else begin
      int ofs, v;
      bit ev, isdiv, low, cen, fire, match;
      ev    = snoop_valid_i && snoop_is_mem_i;
      ofs   = int'(snoop_addr_i - base_addr_i);
      v     = int'(snoop_data_i);
      isdiv = ev && ofs == OFS_DIV;
      low   = isdiv && v <= 44;
      cen   = ev && ofs == OFS_CNT && v % 2 == 1;
      if (ev && ofs == OFS_CLK) m_clk = v;
      if (ev && ofs == OFS_CNT) m_src = v;
      match = m_armed && cen;
      if (m_armed) m_armed = !(isdiv || cen);
      else         m_armed = low;
      fire = match && ((m_clk / 2) % 4 == 1) && ((m_src / 2) % 4 == 0);
      if (m_valid) begin
        if (req_ready_i) m_valid = 0;
      end else if (fire) begin
        m_valid = 1;
        m_addr  = longint'(base_addr_i) + OFS_DIV;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(req_valid_o == m_valid, "R10 model valid", req_valid_o, m_valid);
      if (m_valid)
        chk(req_addr_o == m_addr[AW-1:0], "R9 model addr", req_addr_o, m_addr);
    end
  end

  task automatic wr(input int ofs, input int data, input bit mem = 1);
    snoop_valid_i  = 1'b1;
    snoop_is_mem_i = mem;
    snoop_addr_i   = base_addr_i + AW'(ofs);
    snoop_data_i   = SW'(data);
    @(negedge clk_i);
    snoop_valid_i  = 1'b0;
    snoop_is_mem_i = 1'b0;
    snoop_addr_i   = '0;
    snoop_data_i   = '0;
  endtask

  task automatic ack();
    req_ready_i = 1'b1;
    @(negedge clk_i);
    req_ready_i = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    chk(req_valid_o == 1'b0, tag, req_valid_o, 0);
  endtask

  task automatic expect_req(input string tag);
    chk(req_valid_o == 1'b1, tag, req_valid_o, 1);
    chk(req_addr_o == base_addr_i + AW'(OFS_DIV), {tag, " R9 addr"},
        req_addr_o, base_addr_i + AW'(OFS_DIV));
    chk(req_data_o == 45, {tag, " R9 data"}, req_data_o, 45);
    chk(req_is_mem_o == 1'b1, {tag, " R9 mem"}, req_is_mem_o, 1);
    chk(req_be_o == 4'b0011, {tag, " R9 be"}, req_be_o, 4'b0011);
    ack();
    chk(req_valid_o == 1'b0, {tag, " R10 drop"}, req_valid_o, 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state, zero clock-source shadow blocks correction
    expect_none("R1 reset valid");
    wr(OFS_DIV, 10); wr(OFS_CNT, 1);
    expect_none("R1 zero shadow no request");

    // R4 / R8: basic match with setters in between
    wr(OFS_CLK, 2); wr(OFS_DIV, 3); wr(OFS_CLK, 2); wr(OFS_CNT, 0);
    expect_none("R4 armed no request yet");
    wr(OFS_CNT, 1);
    expect_req("R4 match");
    // R4: pattern repeats
    wr(OFS_DIV, 0); wr(OFS_CNT, 1);
    expect_req("R4 second round");

    // R3: boundaries of the divisor classes
    wr(OFS_DIV, 44); wr(OFS_CNT, 1);
    expect_req("R3 value 44 unsafe");
    wr(OFS_DIV, 45); wr(OFS_CNT, 1);
    expect_none("R3 value 45 safe");
    wr(OFS_DIV, 65535); wr(OFS_CNT, 1);
    expect_none("R3 value 65535 safe");

    // R5: misfits while armed
    wr(OFS_DIV, 5); wr(OFS_DIV, 5); wr(OFS_CNT, 1);
    expect_none("R5 second unsafe divisor resets");
    wr(OFS_DIV, 5); wr(OFS_DIV, 100); wr(OFS_CNT, 1);
    expect_none("R5 safe divisor resets");
    wr(OFS_CNT, 1);
    expect_none("R5 enable while idle");

    // R6: enable bit 0 clear is only a source write
    wr(OFS_DIV, 7); wr(OFS_CNT, 16'hFFFE);
    expect_none("R6 bit0 clear no match");
    wr(OFS_CNT, 1);
    expect_req("R6 enable after setter");

    // R8: unsafe combination only
    wr(OFS_CLK, 6); wr(OFS_DIV, 1); wr(OFS_CNT, 1);
    expect_none("R8 clock sel 11");
    wr(OFS_CLK, 2); wr(OFS_DIV, 1); wr(OFS_CNT, 5);
    expect_none("R8 source sel 10");
    wr(OFS_CLK, 16'hFFF3); wr(OFS_DIV, 1); wr(OFS_CNT, 16'h0009);
    expect_req("R8 upper bits ignored");

    // R7: same-cycle source value decides
    wr(OFS_CLK, 2); wr(OFS_DIV, 2); wr(OFS_CNT, 4); wr(OFS_CNT, 1);
    expect_req("R7 new source used");
    // R7: clock shadow loaded while idle, kept across
    wr(OFS_CLK, 0); wr(OFS_CLK, 2); wr(OFS_DIV, 2); wr(OFS_CNT, 1);
    expect_req("R7 idle load kept");

    // R2: I/O writes and other offsets ignored
    wr(OFS_DIV, 10, 0); wr(OFS_CNT, 1);
    expect_none("R2 io divisor ignored");
    wr(OFS_DIV, 10); wr('h224, 0); wr(OFS_DIV, 50, 0); wr(OFS_CLK, 6, 0);
    wr(OFS_CNT, 1, 0);
    expect_none("R2 io enable ignored");
    wr(OFS_CNT, 1);
    expect_req("R2 still armed after ignored writes");

    // R10 / R11: pending request holds, second match dropped
    wr(OFS_DIV, 9); wr(OFS_CNT, 1);
    chk(req_valid_o == 1'b1, "R10 pending", req_valid_o, 1);
    begin
      logic [AW-1:0] held;
      held = req_addr_o;
      base_addr_i = 32'h5000_0000;
      repeat (3) @(negedge clk_i);
      chk(req_addr_o == held, "R10 addr held", req_addr_o, held);
      base_addr_i = 32'h4000_0000;
    end
    wr(OFS_DIV, 9); wr(OFS_CNT, 1);
    chk(req_valid_o == 1'b1, "R11 still pending", req_valid_o, 1);
    ack();
    chk(req_valid_o == 1'b0, "R10 released", req_valid_o, 0);
    repeat (2) @(negedge clk_i);
    expect_none("R11 dropped match");

    // R9: new base picked at issue
    base_addr_i = 32'h0001_0000;
    wr(OFS_CLK, 2); wr(OFS_DIV, 1); wr(OFS_CNT, 1);
    expect_req("R9 new base");

    // R1: reset mid-pattern clears sequencer and shadows
    wr(OFS_DIV, 1);
    do_reset();
    wr(OFS_CNT, 1);
    expect_none("R1 armed cleared");
    wr(OFS_DIV, 1); wr(OFS_CNT, 1);
    expect_none("R1 clock shadow cleared");

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule